// File: doc/BRIEF.md
# Sensor Line and Frame Blanking Sequencer

This block paces the readout of an image sensor. A pixel counter runs at the pixel clock and restarts on every line-start strobe. A line counter restarts on the frame-start strobe and advances on each line start. A horizontal state machine turns the pixel count into a position along the line. A line is laid out as a vertical-shift interval, then dummy pixels, then front optical-black pixels, then effective pixels, then back optical-black pixels, then an idle tail. A vertical state machine does the same for the line count: front optical-black lines, effective lines, back optical-black lines, then idle.

Three strobes are decoded from the two states and registered. The clamp pulse marks the back optical-black pixels of every line. The output-blanking pulse, when enabled, marks every pixel that is not an effective pixel on an effective line. The horizontal-blanking pulse covers the vertical-shift interval. A clamp mask, given as a first and last line, switches the clamp off on a range of lines and leaves the region sizes untouched. All sizes are static inputs that change only between frames.

Horizontal states: H_SHIFT, H_DUMMY, H_FRONT_OB, H_ACTIVE, H_BACK_OB, H_IDLE. The machine leaves each state when the next pixel count reaches that state's end boundary, and the zero-length regions that follow are skipped. Any state goes to the state of pixel 0 on a restart. H_IDLE is left only on a restart. Vertical states: V_FRONT_OB, V_ACTIVE, V_BACK_OB, V_IDLE. These move the same way on line boundaries, and a frame start sends any of them back to the state of line 0. After reset both machines sit in their idle state.

Top module: `sensor_blank_seq`

## Requirements
- R1: `pix_cnt` becomes 0 in the cycle after `line_start` or `frame_start` is high. Otherwise it rises by one per clock and holds at its maximum value 2^PIX_W-1.
- R2: `line_cnt` becomes 0 in the cycle after `frame_start` is high. It rises by one in the cycle after a `line_start` that comes without `frame_start`.
- R3: `hblank` is high exactly for the pixel counts p with p < `vshift_len`, one cycle late (see R9).
- R4: The dummy pixels, counts from `vshift_len` up to `vshift_len`+`dummy_len`-1, drive neither `hblank` nor `clamp`. When blanking is enabled they are blanked.
- R5: `clamp` is high for the back optical-black counts, from B4 = `vshift_len`+`dummy_len`+`front_ob_pix`+`active_pix` up to B4+`back_ob_pix`-1, on every line that is not masked. `clamp` and `hblank` are never high together.
- R6: `clamp` is low on every line L with `mask_first` ≤ L ≤ `mask_last`, the mask being inclusive at both ends. When `mask_first` > `mask_last` no line is masked.
- R7: With `pblk_en` = 1, `blank_out` is low only for effective pixels on effective lines. Effective pixels are counts from B4-`active_pix` up to B4-1. Effective lines are counts from `front_ob_lines` up to `front_ob_lines`+`active_lines`-1.
- R8: With `pblk_en` = 0, `blank_out` stays low.
- R9: Every strobe describes the pixel and line counts shown one cycle earlier.
- R10: During reset the counters read 0 and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_start | input | 1 | Restarts the pixel count and advances the line count |
| frame_start | input | 1 | Restarts both counts; the line in progress becomes line 0 |
| pblk_en | input | 1 | Enables the output-blanking strobe |
| vshift_len | input | PIX_W | Vertical-shift interval length in pixel clocks |
| dummy_len | input | PIX_W | Dummy pixels per line |
| front_ob_pix | input | PIX_W | Front optical-black pixels per line |
| active_pix | input | PIX_W | Effective pixels per line |
| back_ob_pix | input | PIX_W | Back optical-black pixels per line |
| front_ob_lines | input | LINE_W | Front optical-black lines per frame |
| active_lines | input | LINE_W | Effective lines per frame |
| back_ob_lines | input | LINE_W | Back optical-black lines per frame |
| mask_first | input | LINE_W | First line with the clamp masked |
| mask_last | input | LINE_W | Last line with the clamp masked |
| clamp | output | 1 | Black-level clamp strobe |
| blank_out | output | 1 | Output-blanking strobe |
| hblank | output | 1 | Horizontal-blanking strobe for the vertical shift |
| pix_cnt | output | PIX_W | Current pixel count |
| line_cnt | output | LINE_W | Current line count |

## Verification
Whole frames are run under several region layouts. One layout has a nonzero shift interval and lines longer than the layout, so every horizontal boundary and the idle tail are crossed. A second has no shift interval at all, which shows whether a zero-length region is skipped correctly. Mask settings include a two-line range, a single line, the first line and an inverted range, which together separate inclusive ends from an off-by-one and show that the inverted range disables the mask. One very long line drives the pixel counter into saturation. Every cycle, each strobe is compared with the value the bench works out for the previous cycle's counts, and this exposes any extra or missing register stage.

// File: rtl/sensor_blank_seq_pkg.sv
package sensor_blank_seq_pkg;

    typedef enum logic [2:0] {
        H_SHIFT,
        H_DUMMY,
        H_FRONT_OB,
        H_ACTIVE,
        H_BACK_OB,
        H_IDLE
    } hreg_e;

    typedef enum logic [1:0] {
        V_FRONT_OB,
        V_ACTIVE,
        V_BACK_OB,
        V_IDLE
    } vreg_e;

endpackage

// File: rtl/bseq_counter.sv
module bseq_counter #(
    parameter int PIX_W  = 12,
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic              frame_start,
    output logic              restart,
    output logic [PIX_W-1:0]  pix_q,
    output logic [PIX_W-1:0]  pix_nxt,
    output logic [LINE_W-1:0] line_q,
    output logic [LINE_W-1:0] line_nxt
);
    localparam logic [PIX_W-1:0]  PIX_MAX  = '1;
    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    assign restart = line_start | frame_start;

    always_comb begin
        if (restart)
            pix_nxt = '0;
        else if (pix_q == PIX_MAX)
            pix_nxt = pix_q;
        else
            pix_nxt = pix_q + 1'b1;

        if (frame_start)
            line_nxt = '0;
        else if (line_start && line_q != LINE_MAX)
            line_nxt = line_q + 1'b1;
        else
            line_nxt = line_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_q  <= '0;
            line_q <= '0;
        end else begin
            pix_q  <= pix_nxt;
            line_q <= line_nxt;
        end
    end
endmodule

// File: rtl/bseq_region_fsm.sv
module bseq_region_fsm
    import sensor_blank_seq_pkg::*;
#(
    parameter int PIX_W  = 12,
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              frame_start,
    input  logic [PIX_W-1:0]  pix_nxt,
    input  logic [LINE_W-1:0] line_nxt,
    input  logic [PIX_W-1:0]  vshift_len,
    input  logic [PIX_W-1:0]  dummy_len,
    input  logic [PIX_W-1:0]  front_ob_pix,
    input  logic [PIX_W-1:0]  active_pix,
    input  logic [PIX_W-1:0]  back_ob_pix,
    input  logic [LINE_W-1:0] front_ob_lines,
    input  logic [LINE_W-1:0] active_lines,
    input  logic [LINE_W-1:0] back_ob_lines,
    output hreg_e             hstate,
    output vreg_e             vstate
);
    localparam int BW = PIX_W + 3;
    localparam int LW = LINE_W + 2;

    logic [BW-1:0] hb1, hb2, hb3, hb4, hb5, px;
    logic [LW-1:0] vb1, vb2, vb3, ln;
    hreg_e hdec, hnext;
    vreg_e vdec, vnext;

    // Region end boundaries along a line and down a frame
    assign hb1 = BW'(vshift_len);
    assign hb2 = hb1 + BW'(dummy_len);
    assign hb3 = hb2 + BW'(front_ob_pix);
    assign hb4 = hb3 + BW'(active_pix);
    assign hb5 = hb4 + BW'(back_ob_pix);
    assign px  = BW'(pix_nxt);

    assign vb1 = LW'(front_ob_lines);
    assign vb2 = vb1 + LW'(active_lines);
    assign vb3 = vb2 + LW'(back_ob_lines);
    assign ln  = LW'(line_nxt);

    always_comb begin
        if (px < hb1)      hdec = H_SHIFT;
        else if (px < hb2) hdec = H_DUMMY;
        else if (px < hb3) hdec = H_FRONT_OB;
        else if (px < hb4) hdec = H_ACTIVE;
        else if (px < hb5) hdec = H_BACK_OB;
        else               hdec = H_IDLE;

        if (ln < vb1)      vdec = V_FRONT_OB;
        else if (ln < vb2) vdec = V_ACTIVE;
        else if (ln < vb3) vdec = V_BACK_OB;
        else               vdec = V_IDLE;
    end

    // Horizontal transitions: leave a region at its end boundary
    always_comb begin
        hnext = hstate;
        unique case (hstate)
            H_SHIFT:    if (restart || px >= hb1) hnext = hdec;
            H_DUMMY:    if (restart || px >= hb2) hnext = hdec;
            H_FRONT_OB: if (restart || px >= hb3) hnext = hdec;
            H_ACTIVE:   if (restart || px >= hb4) hnext = hdec;
            H_BACK_OB:  if (restart || px >= hb5) hnext = hdec;
            H_IDLE:     if (restart)              hnext = hdec;
            default:    hnext = H_IDLE;
        endcase
    end

    // Vertical transitions: same scheme on line boundaries
    always_comb begin
        vnext = vstate;
        unique case (vstate)
            V_FRONT_OB: if (frame_start || ln >= vb1) vnext = vdec;
            V_ACTIVE:   if (frame_start || ln >= vb2) vnext = vdec;
            V_BACK_OB:  if (frame_start || ln >= vb3) vnext = vdec;
            V_IDLE:     if (frame_start)              vnext = vdec;
            default:    vnext = V_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hstate <= H_IDLE;
            vstate <= V_IDLE;
        end else begin
            hstate <= hnext;
            vstate <= vnext;
        end
    end
endmodule

// File: rtl/bseq_strobes.sv
module bseq_strobes
    import sensor_blank_seq_pkg::*;
#(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  hreg_e             hstate,
    input  vreg_e             vstate,
    input  logic [LINE_W-1:0] line_q,
    input  logic [LINE_W-1:0] mask_first,
    input  logic [LINE_W-1:0] mask_last,
    input  logic              pblk_en,
    output logic              clamp,
    output logic              blank_out,
    output logic              hblank
);
    logic masked;
    logic clamp_d, blank_d, hblank_d;

    always_comb begin
        masked   = (mask_first <= mask_last) &&
                   (line_q >= mask_first) && (line_q <= mask_last);
        clamp_d  = (hstate == H_BACK_OB) && !masked;
        hblank_d = (hstate == H_SHIFT);
        blank_d  = pblk_en && !((hstate == H_ACTIVE) && (vstate == V_ACTIVE));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clamp     <= 1'b0;
            blank_out <= 1'b0;
            hblank    <= 1'b0;
        end else begin
            clamp     <= clamp_d;
            blank_out <= blank_d;
            hblank    <= hblank_d;
        end
    end
endmodule

// File: rtl/sensor_blank_seq.sv
module sensor_blank_seq
    import sensor_blank_seq_pkg::*;
#(
    parameter int PIX_W  = 12,
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic              frame_start,
    input  logic              pblk_en,
    input  logic [PIX_W-1:0]  vshift_len,
    input  logic [PIX_W-1:0]  dummy_len,
    input  logic [PIX_W-1:0]  front_ob_pix,
    input  logic [PIX_W-1:0]  active_pix,
    input  logic [PIX_W-1:0]  back_ob_pix,
    input  logic [LINE_W-1:0] front_ob_lines,
    input  logic [LINE_W-1:0] active_lines,
    input  logic [LINE_W-1:0] back_ob_lines,
    input  logic [LINE_W-1:0] mask_first,
    input  logic [LINE_W-1:0] mask_last,
    output logic              clamp,
    output logic              blank_out,
    output logic              hblank,
    output logic [PIX_W-1:0]  pix_cnt,
    output logic [LINE_W-1:0] line_cnt
);
    logic              restart;
    logic [PIX_W-1:0]  pix_nxt;
    logic [LINE_W-1:0] line_nxt;
    hreg_e             hstate;
    vreg_e             vstate;

    bseq_counter #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_start  (line_start),
        .frame_start (frame_start),
        .restart     (restart),
        .pix_q       (pix_cnt),
        .pix_nxt     (pix_nxt),
        .line_q      (line_cnt),
        .line_nxt    (line_nxt)
    );

    bseq_region_fsm #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .restart        (restart),
        .frame_start    (frame_start),
        .pix_nxt        (pix_nxt),
        .line_nxt       (line_nxt),
        .vshift_len     (vshift_len),
        .dummy_len      (dummy_len),
        .front_ob_pix   (front_ob_pix),
        .active_pix     (active_pix),
        .back_ob_pix    (back_ob_pix),
        .front_ob_lines (front_ob_lines),
        .active_lines   (active_lines),
        .back_ob_lines  (back_ob_lines),
        .hstate         (hstate),
        .vstate         (vstate)
    );

    bseq_strobes #(.LINE_W(LINE_W)) u_str (
        .clk        (clk),
        .rst_n      (rst_n),
        .hstate     (hstate),
        .vstate     (vstate),
        .line_q     (line_cnt),
        .mask_first (mask_first),
        .mask_last  (mask_last),
        .pblk_en    (pblk_en),
        .clamp      (clamp),
        .blank_out  (blank_out),
        .hblank     (hblank)
    );
endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
    parameter int PIX_W  = 12,
    parameter int LINE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_start,
    input logic              frame_start,
    input logic              pblk_en,
    input logic [PIX_W-1:0]  vshift_len,
    input logic [PIX_W-1:0]  dummy_len,
    input logic [PIX_W-1:0]  front_ob_pix,
    input logic [PIX_W-1:0]  active_pix,
    input logic [PIX_W-1:0]  back_ob_pix,
    input logic [LINE_W-1:0] front_ob_lines,
    input logic [LINE_W-1:0] active_lines,
    input logic [LINE_W-1:0] back_ob_lines,
    input logic [LINE_W-1:0] mask_first,
    input logic [LINE_W-1:0] mask_last,
    input logic              clamp,
    input logic              blank_out,
    input logic              hblank,
    input logic [PIX_W-1:0]  pix_cnt,
    input logic [LINE_W-1:0] line_cnt
);
    localparam int BW = PIX_W + 3;
    localparam logic [PIX_W-1:0]  PMAX = '1;
    localparam logic [LINE_W-1:0] LMAX = '1;

    logic [BW-1:0] bob_lo, bob_hi;
    assign bob_lo = BW'(vshift_len) + BW'(dummy_len) + BW'(front_ob_pix) + BW'(active_pix);
    assign bob_hi = bob_lo + BW'(back_ob_pix);

    AST_PIX_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start || frame_start) |=> pix_cnt == '0);                       // R1
    AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_start && !frame_start && pix_cnt != PMAX)
            |=> pix_cnt == $past(pix_cnt) + 1'b1);                            // R1
    AST_LINE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> line_cnt == '0);                                      // R2
    AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !frame_start && line_cnt != LMAX)
            |=> line_cnt == $past(line_cnt) + 1'b1);                          // R2
    AST_HBLK_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        hblank |-> $past(pix_cnt) < $past(vshift_len));                       // R3
    AST_CLAMP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        clamp |-> (BW'($past(pix_cnt)) >= $past(bob_lo)) &&
                  (BW'($past(pix_cnt)) <  $past(bob_hi)));                    // R5
    AST_CLAMP_HBLK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clamp, hblank}));                                           // R5
    AST_CLAMP_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        clamp |-> !(($past(mask_first) <= $past(mask_last)) &&
                    ($past(line_cnt) >= $past(mask_first)) &&
                    ($past(line_cnt) <= $past(mask_last))));                  // R6
    AST_PBLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !pblk_en |=> !blank_out);                                             // R8
endmodule

bind sensor_blank_seq bseq_checker #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_chk (.*);

// File: tb/sensor_blank_seq_test.sv
module sensor_blank_seq_test;
    localparam int PIX_W  = 12;
    localparam int LINE_W = 12;
    localparam int PMAX   = (1 << PIX_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_start = 1'b0;
    logic frame_start = 1'b0;
    logic pblk_en = 1'b0;
    logic [PIX_W-1:0]  vshift_len = '0, dummy_len = '0, front_ob_pix = '0,
                       active_pix = '0, back_ob_pix = '0;
    logic [LINE_W-1:0] front_ob_lines = '0, active_lines = '0, back_ob_lines = '0,
                       mask_first = '0, mask_last = '0;
    logic clamp, blank_out, hblank;
    logic [PIX_W-1:0]  pix_cnt;
    logic [LINE_W-1:0] line_cnt;

    int errors = 0;
    int checks = 0;
    bit valid = 0;
    bit e_clamp, e_blank, e_hblk;
    string t_clamp, t_blank, t_hblk;
    bit finished = 0;

    always #2 clk = ~clk;

    sensor_blank_seq #(.PIX_W(PIX_W), .LINE_W(LINE_W)) uut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Expected strobes for a pixel/line pair under the current settings
    task automatic predict(input int p, input int l);
        int b1, b2, b3, b4, b5;
        bit msk, heff, veff;
        b1 = int'(vshift_len);
        b2 = b1 + int'(dummy_len);
        b3 = b2 + int'(front_ob_pix);
        b4 = b3 + int'(active_pix);
        b5 = b4 + int'(back_ob_pix);
        msk  = (mask_first <= mask_last) && l >= int'(mask_first) && l <= int'(mask_last);
        heff = p >= b3 && p < b4;
        veff = l >= int'(front_ob_lines) && l < int'(front_ob_lines) + int'(active_lines);
        e_hblk  = p < b1;
        e_clamp = p >= b4 && p < b5 && !msk;
        e_blank = pblk_en && !(heff && veff);
        t_hblk  = (p >= b1 && p < b2) ? "R4 hblank" : "R3 hblank";
        t_clamp = (p == b4) ? "R9 clamp" : (msk ? "R6 clamp" :
                  ((p >= b1 && p < b2) ? "R4 clamp" : "R5 clamp"));
        t_blank = !pblk_en ? "R8 blank_out" :
                  ((p >= b1 && p < b2) ? "R4 blank_out" : "R7 blank_out");
    endtask

    task automatic run_line(input bit fs, input int len, input int lidx);
        line_start  = 1'b1;
        frame_start = fs;
        if (fs) valid = 0;
        for (int k = 0; k < len; k++) begin
            int ep;
            @(negedge clk);
            if (k == 0) begin
                line_start  = 1'b0;
                frame_start = 1'b0;
            end
            ep = (k > PMAX) ? PMAX : k;
            chk(int'(pix_cnt) == ep, "R1 pix_cnt", int'(pix_cnt), ep);
            chk(int'(line_cnt) == lidx, "R2 line_cnt", int'(line_cnt), lidx);
            if (valid) begin
                chk(hblank == e_hblk, t_hblk, hblank, e_hblk);
                chk(clamp == e_clamp, t_clamp, clamp, e_clamp);
                chk(blank_out == e_blank, t_blank, blank_out, e_blank);
            end
            predict(ep, lidx);
            valid = 1;
        end
    endtask

    task automatic run_frame(input int nlines, input int len);
        for (int l = 0; l < nlines; l++)
            run_line(l == 0, len, l);
    endtask

    task automatic set_layout(input int vs, input int dm, input int fo, input int ac,
                              input int bo, input int fl, input int al, input int bl);
        vshift_len = PIX_W'(vs);   dummy_len = PIX_W'(dm);
        front_ob_pix = PIX_W'(fo); active_pix = PIX_W'(ac);
        back_ob_pix = PIX_W'(bo);
        front_ob_lines = LINE_W'(fl); active_lines = LINE_W'(al);
        back_ob_lines = LINE_W'(bl);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        set_layout(3, 2, 1, 4, 3, 2, 3, 1);
        mask_first = 1; mask_last = 2; pblk_en = 1'b1;
        repeat (3) @(negedge clk);
        // R10: quiet outputs in reset
        chk(pix_cnt == '0, "R10 pix_cnt", int'(pix_cnt), 0);
        chk(line_cnt == '0, "R10 line_cnt", int'(line_cnt), 0);
        chk(!clamp && !blank_out && !hblank, "R10 strobes",
            {clamp, blank_out, hblank}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Layout A, mask lines 1..2, blanking on
        run_frame(7, 16);
        // Inverted mask range disables the mask, blanking off
        mask_first = 4; mask_last = 3; pblk_en = 1'b0;
        run_frame(7, 16);
        // Layout B without shift interval, mask only line 0
        set_layout(0, 1, 2, 3, 2, 1, 3, 1);
        mask_first = 0; mask_last = 0; pblk_en = 1'b1;
        run_frame(6, 10);
        // Single masked line, then a long line that saturates the pixel count
        set_layout(3, 2, 1, 4, 3, 2, 3, 1);
        mask_first = 5; mask_last = 5;
        run_frame(7, 16);
        run_line(1'b0, 4100, 7);
        run_line(1'b0, 16, 8);
        summary();
    end
endmodule